// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a two-level AND-OR array in which both planes are programmable. Each primary input gives a true and a complemented literal. Every product term ANDs any subset of those literals, and every output ORs any subset of the product terms. Both planes are programmable, so one product term can serve several outputs. The constant cases need no extra logic: a term with no literals selected is 1, and an output that selects no terms is 0. With the default size of 4 inputs, 6 terms and 3 outputs, the array can implement any three 4-input functions that need six or fewer distinct product terms between them.

The connection map is loaded one bit per clock through a serial port. Holding `cfg_en` high streams the bits into a staging copy of the map. The live map takes the staged copy on the first clock edge after `cfg_en` falls. From that edge on, the outputs are a purely combinational function of `in_vec`. The outputs are held at 0 for the whole load window, so no mixture of an old map and a new map ever appears at the outputs.

Top module: `pla_sop_array`

## Requirements
- R1: For every input i, the array offers a true literal and a complemented literal. A product term can require any subset of these 2·N_IN literals to be 1.
- R2: A product term that selects no literal evaluates to 1.
- R3: A product term that selects both the true and the complemented literal of the same input evaluates to 0.
- R4: Each output is the OR of the product terms it selects. One product term can drive several outputs at the same time.
- R5: An output that selects no product term is constant 0.
- R6: The map is a stream of N_TERM·2·N_IN + N_OUT·N_TERM bits, and its first bit is bit 0. Stream bit t·2·N_IN + 2·i selects the true literal of input i into term t. Bit t·2·N_IN + 2·i + 1 selects the complement of input i into term t. Bit N_TERM·2·N_IN + o·N_TERM + t connects term t to output o. One bit, `cfg_bit`, is captured on each rising `clk` edge while `cfg_en` is 1.
- R7: `out_vec` is 0 while `cfg_en` is 1. It stays 0 until the first rising edge at which `cfg_en` is sampled 0. The staged map becomes live at that edge.
- R8: `cfg_done` is 1 for exactly one cycle, starting at the edge that captures the last stream bit of a load.
- R9: Bits sent after the full stream length within the same `cfg_en` window are ignored. They do not change the map, and they do not raise `cfg_done` again.
- R10: After reset, the live map and the staged map are empty, `out_vec` is 0 and `cfg_done` is 0.
- R11: Outside a load, `out_vec` follows `in_vec` combinationally through the live map, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port and the map registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | High while map bits are being streamed in |
| cfg_bit | input | 1 | Serial map bit, captured while cfg_en is high |
| in_vec | input | N_IN | Primary inputs of the array |
| out_vec | output | N_OUT | Sum-of-products outputs |
| cfg_done | output | 1 | One-cycle pulse when the last map bit is captured |

## Verification
Every map is swept over all sixteen input combinations. In the first map, one term is shared by two outputs and the other terms use mixed true and complemented literals. This tells apart errors in literal polarity, in bit ordering and in term sharing. A second map routes an empty term, an all-complement term and a self-contradicting term to separate outputs, which exposes the constant-1 and constant-0 cases on their own. Reloading the first map with surplus 1 bits after the stream shows whether extra bits wrap around into the map. A reference model that follows the stream bit by bit compares the outputs and the load pulse on every clock.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

    // Length of the serial map: AND plane followed by OR plane.
    function automatic int unsigned cfg_len(input int unsigned n_in,
                                            input int unsigned n_term,
                                            input int unsigned n_out);
        return n_term * 2 * n_in + n_out * n_term;
    endfunction

    // Position of a literal inside one term's selection field.
    function automatic int unsigned lit_pos(input int unsigned inp,
                                            input bit complemented);
        return 2 * inp + (complemented ? 1 : 0);
    endfunction

endpackage

// File: rtl/pla_cfg_loader.sv
`timescale 1ns/1ps
module pla_cfg_loader #(
    parameter int unsigned CFG_BITS = 66
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_bit,
    output logic [CFG_BITS-1:0] shadow,
    output logic                commit,
    output logic                busy,
    output logic                cfg_done
);
    localparam int unsigned CW = $clog2(CFG_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(CFG_BITS - 1);

    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic [CFG_BITS-1:0] map;
        logic                en;
        logic                done;
    } ld_t;

    ld_t st_d, st_q;

    // Next-state: write the addressed bit, stop at the stream length.
    always_comb begin
        st_d      = st_q;
        st_d.en   = cfg_en;
        st_d.done = 1'b0;
        if (cfg_en) begin
            if (st_q.cnt <= LAST) begin
                st_d.map[st_q.cnt] = cfg_bit;
                st_d.done          = (st_q.cnt == LAST);
                st_d.cnt           = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow   = st_q.map;
    assign commit   = st_q.en & ~cfg_en;
    assign busy     = cfg_en | st_q.en;
    assign cfg_done = st_q.done;

endmodule

// File: rtl/pla_literal_gen.sv
`timescale 1ns/1ps
module pla_literal_gen #(
    parameter int unsigned N_IN = 4
) (
    input  logic [N_IN-1:0]   in_vec,
    output logic [2*N_IN-1:0] lits
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[pla_pkg::lit_pos(i, 1'b0)] = in_vec[i];
        assign lits[pla_pkg::lit_pos(i, 1'b1)] = ~in_vec[i];
    end
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_TERM = 6
) (
    input  logic [2*N_IN-1:0]        lits,
    input  logic [N_TERM*2*N_IN-1:0] sel,
    output logic [N_TERM-1:0]        terms
);
    localparam int unsigned LW = 2 * N_IN;

    // An unselected literal reads as 1, so an empty term is 1 and a
    // term holding x and ~x is 0 without any special case.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign terms[t] = &(lits | ~sel[t*LW +: LW]);
    end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
    parameter int unsigned N_TERM = 6,
    parameter int unsigned N_OUT  = 3
) (
    input  logic [N_TERM-1:0]       terms,
    input  logic [N_OUT*N_TERM-1:0] sel,
    output logic [N_OUT-1:0]        sums
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sums[o] = |(terms & sel[o*N_TERM +: N_TERM]);
    end
endmodule

// File: rtl/pla_sop_array.sv
`timescale 1ns/1ps
module pla_sop_array #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_TERM = 6,
    parameter int unsigned N_OUT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec,
    output logic             cfg_done
);
    localparam int unsigned AND_BITS = N_TERM * 2 * N_IN;
    localparam int unsigned OR_BITS  = N_OUT * N_TERM;
    localparam int unsigned CFG_BITS = pla_pkg::cfg_len(N_IN, N_TERM, N_OUT);

    logic [CFG_BITS-1:0] shadow;
    logic                commit;
    logic                busy;
    logic [CFG_BITS-1:0] act_d, act_q;
    logic [2*N_IN-1:0]   lits;
    logic [N_TERM-1:0]   terms;
    logic [N_OUT-1:0]    sums;

    pla_cfg_loader #(.CFG_BITS(CFG_BITS)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_bit  (cfg_bit),
        .shadow   (shadow),
        .commit   (commit),
        .busy     (busy),
        .cfg_done (cfg_done)
    );

    // Live map: takes the staged copy on the edge after cfg_en falls.
    always_comb begin
        act_d = act_q;
        if (commit) begin
            act_d = shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    pla_literal_gen #(.N_IN(N_IN)) u_lits (
        .in_vec (in_vec),
        .lits   (lits)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .lits  (lits),
        .sel   (act_q[AND_BITS-1:0]),
        .terms (terms)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .terms (terms),
        .sel   (act_q[AND_BITS +: OR_BITS]),
        .sums  (sums)
    );

    assign out_vec = busy ? '0 : sums;

endmodule

// File: rtl/pla_sop_array_chk.sv
`timescale 1ns/1ps
module pla_sop_array_chk #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_OUT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_done,
    input logic [N_IN-1:0]  in_vec,
    input logic [N_OUT-1:0] out_vec
);
    p_quiet_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (out_vec == '0));

    p_quiet_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_en) && !cfg_en) |-> (out_vec == '0));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    p_done_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> $past(cfg_en));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !$past(cfg_en) && !$past(cfg_en, 2) && $stable(in_vec))
            |-> $stable(out_vec));
endmodule

bind pla_sop_array pla_sop_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_done (cfg_done),
    .in_vec   (in_vec),
    .out_vec  (out_vec)
);

// File: tb/pla_sop_array_test.sv
`timescale 1ns/1ps
module pla_sop_array_test;
    localparam int NI = 4;
    localparam int NT = 6;
    localparam int NO = 3;
    localparam int AB = NT * 2 * NI;
    localparam int CB = AB + NO * NT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic [NO-1:0] out_vec;
    logic          cfg_done;

    int  nchk = 0;
    int  nfail = 0;
    int  done_cnt = 0;
    bit  fin = 1'b0;

    // Behavioural reference state.
    logic [CB-1:0] m_shadow, m_active;
    int            m_cnt;
    bit            m_enq, m_done;

    logic [CB-1:0] map_a, map_b;

    always #4 clk = ~clk;

    pla_sop_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_bit  (cfg_bit),
        .in_vec   (in_vec),
        .out_vec  (out_vec),
        .cfg_done (cfg_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CB-1:0] add_lit(input logic [CB-1:0] m, input int t,
                                              input int i, input bit neg);
        m[t*2*NI + 2*i + (neg ? 1 : 0)] = 1'b1;
        return m;
    endfunction

    function automatic logic [CB-1:0] add_or(input logic [CB-1:0] m, input int o, input int t);
        m[AB + o*NT + t] = 1'b1;
        return m;
    endfunction

    // Reference evaluation of a map, written from the requirements.
    function automatic logic [NO-1:0] ref_eval(input logic [CB-1:0] m, input logic [NI-1:0] x);
        logic [NO-1:0] r = '0;
        for (int t = 0; t < NT; t++) begin
            bit tv = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (m[t*2*NI + 2*i] && !x[i]) tv = 1'b0;
                if (m[t*2*NI + 2*i + 1] && x[i]) tv = 1'b0;
            end
            for (int o = 0; o < NO; o++) begin
                if (tv && m[AB + o*NT + t]) r[o] = 1'b1;
            end
        end
        return r;
    endfunction

    // Hand-written equations of the two maps.
    function automatic logic [NO-1:0] eq_a(input logic [NI-1:0] x);
        logic [NO-1:0] r;
        r[0] = (x[0] & x[1]) | (~x[2] & x[3]);
        r[1] = (x[0] & x[1]) | (x[2] & ~x[3]);
        r[2] = 1'b0;
        return r;
    endfunction

    function automatic logic [NO-1:0] eq_b(input logic [NI-1:0] x);
        logic [NO-1:0] r;
        r[0] = 1'b1;
        r[1] = (x == '0);
        r[2] = 1'b0;
        return r;
    endfunction

    // Reference model update, one step per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_shadow = '0; m_active = '0; m_cnt = 0; m_enq = 1'b0; m_done = 1'b0;
        end else begin
            if (m_enq && !cfg_en) m_active = m_shadow;
            if (cfg_en) begin
                if (m_cnt < CB) begin
                    m_shadow[m_cnt] = cfg_bit;
                    m_done = (m_cnt == CB - 1);
                    m_cnt++;
                end else begin
                    m_done = 1'b0;
                end
            end else begin
                m_cnt = 0;
                m_done = 1'b0;
            end
            m_enq = cfg_en;
        end
    end

    // Every-clock comparison against the model (R11 and R8).
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            logic [NO-1:0] e;
            e = (cfg_en || m_enq) ? '0 : ref_eval(m_active, in_vec);
            chk(out_vec == e, "R11 model out", int'(out_vec), int'(e));
            chk(cfg_done == m_done, "R8 model done", int'(cfg_done), int'(m_done));
        end
        if (cfg_done) done_cnt++;
    end

    task automatic load(input logic [CB-1:0] m, input int extra);
        done_cnt = 0;
        for (int k = 0; k < CB + extra; k++) begin
            @(posedge clk); #2;
            cfg_en  = 1'b1;
            cfg_bit = (k < CB) ? m[k] : 1'b1;
            if (k == 10) begin
                @(negedge clk);
                chk(out_vec == '0, "R7 zero during load", int'(out_vec), 0);
            end
        end
        @(posedge clk); #2;
        cfg_en  = 1'b0;
        cfg_bit = 1'b0;
        @(negedge clk);
        chk(out_vec == '0, "R7 zero before commit", int'(out_vec), 0);
        if (extra == 0) chk(cfg_done == 1'b1, "R8 done after last bit", int'(cfg_done), 1);
        @(posedge clk); #2;
        @(negedge clk);
        chk(cfg_done == 1'b0, "R8 done single cycle", int'(cfg_done), 0);
        chk(done_cnt == 1, "R9 one done per load", done_cnt, 1);
    endtask

    task automatic sweep(input bit use_b, input string tag);
        for (int x = 0; x < 16; x++) begin
            logic [NO-1:0] e;
            @(posedge clk); #2;
            in_vec = 4'(x);
            e = use_b ? eq_b(4'(x)) : eq_a(4'(x));
            @(negedge clk);
            chk(out_vec == e, tag, int'(out_vec), int'(e));
        end
    endtask

    initial begin
        // Map A: P0=i0&i1, P1=~i2&i3, P2=i2&~i3, P3=empty, P4=i0&~i0,
        // P5=~i0&~i1&~i2&~i3.
        map_a = '0;
        map_a = add_lit(map_a, 0, 0, 0); map_a = add_lit(map_a, 0, 1, 0);
        map_a = add_lit(map_a, 1, 2, 1); map_a = add_lit(map_a, 1, 3, 0);
        map_a = add_lit(map_a, 2, 2, 0); map_a = add_lit(map_a, 2, 3, 1);
        map_a = add_lit(map_a, 4, 0, 0); map_a = add_lit(map_a, 4, 0, 1);
        for (int i = 0; i < NI; i++) map_a = add_lit(map_a, 5, i, 1);
        map_b = map_a;
        map_a = add_or(map_a, 0, 0); map_a = add_or(map_a, 0, 1);
        map_a = add_or(map_a, 1, 0); map_a = add_or(map_a, 1, 2);
        map_a = add_or(map_a, 1, 4);
        map_b = add_or(map_b, 0, 3);
        map_b = add_or(map_b, 1, 5);
        map_b = add_or(map_b, 2, 4);

        // R10: reset state.
        for (int x = 0; x < 3; x++) begin
            @(posedge clk); #2; in_vec = 4'(x * 5);
            @(negedge clk);
            chk(out_vec == '0, "R10 reset out", int'(out_vec), 0);
            chk(cfg_done == 1'b0, "R10 reset done", int'(cfg_done), 0);
        end
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(out_vec == '0, "R10 empty map after reset", int'(out_vec), 0);

        in_vec = 4'hF;
        load(map_a, 0);
        sweep(1'b0, "R1 R4 R6 R11 map A");
        load(map_b, 0);
        sweep(1'b1, "R2 R3 R5 map B");
        in_vec = 4'h3;
        load(map_a, 9);
        sweep(1'b0, "R9 map A after surplus bits");

        fin = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!fin) begin
            fin = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog R11 actual=0 expected=1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule